// File: doc/BRIEF.md
# Per-pin configurable interrupt detector

This block watches a group of already-synchronized input pins and keeps one sticky status bit per pin. Each pin is given its own trigger type: rising edge, falling edge, any edge, active-high level or active-low level. A qualifying event on a pin sets that pin's status bit on the next clock edge. The bit stays set until a write-one-to-clear pulse removes it.

Every status bit is gated by a per-pin enable. The gated bits are ORed into a single interrupt request. A status bit keeps recording events while its enable is low, so software can poll pins without taking interrupts.

The trigger type arrives as one word made of three bit-planes, one bit per pin in each plane. Register decoding, the bus side and input synchronization are handled outside the block.

Top module: `pin_irq_detect`

## Requirements
- R1: For pin n of PINS, the trigger word holds three fields. Bit n is the polarity (1 = high or rising). Bit PINS+n selects edge mode (1) over level mode (0). Bit 2*PINS+n selects any-edge detection within edge mode and is ignored in level mode. With PINS=8, pin 0 encodes as: rising 0x000101, falling 0x000100, any edge 0x010100, level high 0x000001, level low 0x000000 (any-edge bit clear in both level codes).
- R2: In rising mode, a cycle where the pin is 1 and was 0 on the previous cycle sets the pin's status bit, which is visible after the next clock edge.
- R3: In falling mode, a cycle where the pin is 0 and was 1 on the previous cycle sets the pin's status bit after the next clock edge.
- R4: In any-edge mode, any change of the pin value sets status, whatever the polarity bit holds.
- R5: In level mode, status is set after every clock edge at which the pin equals the polarity. A clear therefore only takes effect once the pin is inactive.
- R6: A set status bit stays set until it is cleared.
- R7: A clear pulse bit of 1 with no event on that pin clears the status bit after the next edge. A later qualifying edge sets it again.
- R8: When a qualifying event and a clear hit the same pin in the same cycle, the status bit ends up set.
- R9: The request is 1 exactly when some status bit and its enable bit are both 1. A disabled pin still updates its status bit.
- R10: Reset (synchronous, active high) clears all status. During reset the previous-value register loads the current pins, so an input held steady through reset release causes no edge.
- R11: A pin change that does not match the pin's trigger type leaves its status bit unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | PINS | Synchronized pin values |
| trig_type | input | 3*PINS | Trigger type planes: polarity, edge select, any-edge select |
| irq_en | input | PINS | Per-pin request enable |
| stat_clr | input | PINS | Write-one-to-clear pulse, one cycle per clear |
| stat_out | output | PINS | Sticky status bits |
| irq_req | output | 1 | OR of status ANDed with enable |

## Verification
The assertions assume that pins, trigger word, enables and clear pulses are already synchronous to the clock and steady around each edge. On that basis they can take the previous sampled pin value as the detector's history, including the reset cycle. They also take the trigger word sampled in a cycle as the type that applies to that cycle's event.

The stimulus changes every input only shortly after a rising edge and holds reset high from time zero. Random trigger words cover all eight three-bit codes per pin, including level codes with the any-edge bit set. Clear pulses are sparse so that set, hold and clear-versus-set races all occur.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    // per-pin trigger field, gathered from three bit-planes
    typedef struct packed {
        logic any_edge;
        logic edge_sel;
        logic pol;
    } trig_cfg_t;

    typedef enum logic [2:0] {
        TRIG_LEVEL_LO  = 3'd0,
        TRIG_LEVEL_HI  = 3'd1,
        TRIG_EDGE_FALL = 3'd2,
        TRIG_EDGE_RISE = 3'd3,
        TRIG_EDGE_ANY  = 3'd4
    } trig_mode_t;

    // the any-edge plane only counts in edge mode; polarity is dropped there
    function automatic trig_mode_t decode_mode(trig_cfg_t cfg);
        trig_mode_t m;
        if (!cfg.edge_sel)
            m = cfg.pol ? TRIG_LEVEL_HI : TRIG_LEVEL_LO;
        else if (cfg.any_edge)
            m = TRIG_EDGE_ANY;
        else
            m = cfg.pol ? TRIG_EDGE_RISE : TRIG_EDGE_FALL;
        return m;
    endfunction

    function automatic logic trig_event(trig_mode_t m, logic cur, logic prev);
        logic hit;
        case (m)
            TRIG_LEVEL_LO:  hit = ~cur;
            TRIG_LEVEL_HI:  hit = cur;
            TRIG_EDGE_FALL: hit = ~cur & prev;
            TRIG_EDGE_RISE: hit = cur & ~prev;
            TRIG_EDGE_ANY:  hit = cur ^ prev;
            default:        hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pin_history.sv
module pin_history #(
    parameter int PINS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] pin_prev
);
    // reset also loads the live value so release cannot fake an edge
    always_ff @(posedge clk) begin
        if (rst)
            pin_prev <= pin_in;
        else
            pin_prev <= pin_in;
    end
endmodule

// File: rtl/pin_trigger_cell.sv
module pin_trigger_cell
    import pin_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  trig_cfg_t cfg,
    input  logic      cur,
    input  logic      prev,
    input  logic      clr,
    output logic      stat
);
    trig_mode_t mode;
    logic       hit;

    always_comb begin
        mode = decode_mode(cfg);
        hit  = trig_event(mode, cur, prev);
    end

    // a new event outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            stat <= 1'b0;
        else
            stat <= (stat & ~clr) | hit;
    end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
    parameter int PINS = 8
) (
    input  logic [PINS-1:0] stat,
    input  logic [PINS-1:0] en,
    output logic            req
);
    logic [PINS-1:0] gated;

    always_comb begin
        gated = stat & en;
        req   = |gated;
    end
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
    import pin_irq_pkg::*;
#(
    parameter int PINS = 8,
    localparam int TW = 3 * PINS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] pin_in,
    input  logic [TW-1:0]   trig_type,
    input  logic [PINS-1:0] irq_en,
    input  logic [PINS-1:0] stat_clr,
    output logic [PINS-1:0] stat_out,
    output logic            irq_req
);
    logic [PINS-1:0] prev_q;
    trig_cfg_t       cfg [PINS];

    pin_history #(.PINS(PINS)) u_hist (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .pin_prev (prev_q)
    );

    for (genvar n = 0; n < PINS; n++) begin : g_pin
        assign cfg[n] = '{any_edge: trig_type[2*PINS+n],
                          edge_sel: trig_type[PINS+n],
                          pol:      trig_type[n]};

        pin_trigger_cell u_cell (
            .clk  (clk),
            .rst  (rst),
            .cfg  (cfg[n]),
            .cur  (pin_in[n]),
            .prev (prev_q[n]),
            .clr  (stat_clr[n]),
            .stat (stat_out[n])
        );
    end

    irq_merge #(.PINS(PINS)) u_merge (
        .stat (stat_out),
        .en   (irq_en),
        .req  (irq_req)
    );
endmodule

// File: rtl/pin_irq_detect_chk.sv
module pin_irq_detect_chk #(
    parameter int PINS = 8,
    localparam int TW = 3 * PINS
) (
    input logic            clk,
    input logic            rst,
    input logic [PINS-1:0] pin_in,
    input logic [TW-1:0]   trig_type,
    input logic [PINS-1:0] irq_en,
    input logic [PINS-1:0] stat_clr,
    input logic [PINS-1:0] stat_out,
    input logic            irq_req
);
    for (genvar k = 0; k < PINS; k++) begin : g_chk
        logic pol, eds, anye;
        assign pol  = trig_type[k];
        assign eds  = trig_type[PINS+k];
        assign anye = trig_type[2*PINS+k];

        AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
            (eds && !anye && pol && pin_in[k] && !$past(pin_in[k])) |=> stat_out[k]); // R2
        AST_FALL_SETS: assert property (@(posedge clk) disable iff (rst)
            (eds && !anye && !pol && !pin_in[k] && $past(pin_in[k])) |=> stat_out[k]); // R3
        AST_ANY_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
            (eds && anye && (pin_in[k] != $past(pin_in[k]))) |=> stat_out[k]); // R4
        AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (rst)
            (!eds && (pin_in[k] == pol)) |=> stat_out[k]); // R5
        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
            (stat_out[k] && !stat_clr[k]) |=> stat_out[k]); // R6
        AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
            (stat_clr[k] && eds && (pin_in[k] == $past(pin_in[k]))) |=> !stat_out[k]); // R7
    end

    AST_IRQ_OR: assert property (@(posedge clk) disable iff (rst)
        irq_req == ((stat_out & irq_en) != '0)); // R9
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (stat_out == '0)); // R10
endmodule

bind pin_irq_detect pin_irq_detect_chk #(.PINS(PINS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .pin_in    (pin_in),
    .trig_type (trig_type),
    .irq_en    (irq_en),
    .stat_clr  (stat_clr),
    .stat_out  (stat_out),
    .irq_req   (irq_req)
);

// File: tb/test_pin_irq_detect.sv
`timescale 1ns/1ps
module test_pin_irq_detect;
    localparam int PINS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pin = 8'hA5;
    logic [23:0] ttype = 24'h00FFFF;
    logic [7:0]  en = 8'h00;
    logic [7:0]  clr = 8'h00;
    logic [7:0]  stat;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [7:0] m_stat = 8'h00;
    logic [7:0] m_prev = 8'h00;

    always #5 clk = ~clk;

    pin_irq_detect #(.PINS(PINS)) i_pin_irq_detect (
        .clk(clk), .rst(rst), .pin_in(pin), .trig_type(ttype),
        .irq_en(en), .stat_clr(clr), .stat_out(stat), .irq_req(irq)
    );

    function automatic logic [7:0] model_events(logic [7:0] c, logic [7:0] p, logic [23:0] t);
        logic [7:0] e;
        for (int k = 0; k < 8; k++) begin
            if (!t[8+k])       e[k] = (c[k] == t[k]);
            else if (t[16+k])  e[k] = c[k] ^ p[k];
            else if (t[k])     e[k] = c[k] & ~p[k];
            else               e[k] = ~c[k] & p[k];
        end
        return e;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        logic [7:0] nxt;
        logic [7:0] pv;
        pv  = pin;
        nxt = rst ? 8'h00 : ((m_stat & ~clr) | model_events(pin, m_prev, ttype));
        @(posedge clk);
        #1;
        m_stat = nxt;
        m_prev = pv;
        cycles++;
        chk("R6 status vs model", {24'h0, stat}, {24'h0, m_stat});
        chk("R9 request vs model", {31'h0, irq}, {31'h0, |(m_stat & en)});
    endtask

    initial begin : watchdog
        #1000000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd4711));
        repeat (3) tick();
        rst = 1'b0;
        // R10: steady pins across release give no edge
        tick();
        chk("R10 no edge after reset", {24'h0, stat}, 32'h0);
        tick();
        chk("R10 still quiet", {24'h0, stat}, 32'h0);
        // R2 rising on pin1, disabled pin still records (R9)
        pin = 8'hA7; tick();
        chk("R2 rise sets", {31'h0, stat[1]}, 32'h1);
        chk("R9 disabled pin no request", {31'h0, irq}, 32'h0);
        en = 8'h02; #1;
        chk("R9 enabled request", {31'h0, irq}, 32'h1);
        // R6 hold; R11 falling ignored in rising mode on pin1 after clear
        pin = 8'hA5; tick();
        chk("R6 status held", {31'h0, stat[1]}, 32'h1);
        clr = 8'h02; tick(); clr = 8'h00;
        chk("R7 clear", {31'h0, stat[1]}, 32'h0);
        chk("R7 request drops", {31'h0, irq}, 32'h0);
        pin = 8'hA7; tick();
        chk("R7 rearmed by new edge", {31'h0, stat[1]}, 32'h1);
        // switch pin1 to falling
        ttype = 24'h00FFFD;
        clr = 8'h02; tick(); clr = 8'h00;
        chk("R7 clear before fall", {31'h0, stat[1]}, 32'h0);
        pin = 8'hA5; tick();
        chk("R3 fall sets", {31'h0, stat[1]}, 32'h1);
        pin = 8'hA7; clr = 8'h02; tick(); clr = 8'h00;
        chk("R11 rise ignored in falling mode", {31'h0, stat[1]}, 32'h0);
        pin = 8'hA5; clr = 8'h02; tick(); clr = 8'h00;
        chk("R8 set wins over clear", {31'h0, stat[1]}, 32'h1);
        // pin2 any-edge, polarity 0
        ttype = (ttype | 24'h040400) & ~24'h000004;
        clr = 8'hFF; tick(); clr = 8'h00;
        pin = 8'hA1; tick();
        chk("R4 fall in any-edge", {31'h0, stat[2]}, 32'h1);
        clr = 8'h04; tick(); clr = 8'h00;
        chk("R7 clear pin2", {31'h0, stat[2]}, 32'h0);
        pin = 8'hA5; tick();
        chk("R4 rise in any-edge", {31'h0, stat[2]}, 32'h1);
        // pin3 level high with any-edge plane set (ignored, R1)
        ttype = (ttype & ~24'h000800) | 24'h080008;
        clr = 8'hFF; tick(); clr = 8'h00;
        chk("R1 level high idle", {31'h0, stat[3]}, 32'h0);
        pin = 8'hAD; tick();
        chk("R5 level high sets", {31'h0, stat[3]}, 32'h1);
        clr = 8'h08; tick();
        chk("R5 clear while active", {31'h0, stat[3]}, 32'h1);
        pin = 8'hA5; tick(); clr = 8'h00;
        chk("R5 clear once inactive", {31'h0, stat[3]}, 32'h0);
        tick();
        chk("R1 any-edge plane ignored in level", {31'h0, stat[3]}, 32'h0);
        // pin4 level low (pin4 is 0)
        ttype = ttype & ~24'h001010;
        tick();
        chk("R5 level low sets", {31'h0, stat[4]}, 32'h1);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 16 == 0) ttype = $urandom;
            if ($urandom % 3 == 0) pin = pin ^ 8'($urandom);
            clr = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
            if ($urandom % 8 == 0) en = 8'($urandom);
            tick();
        end
        clr = 8'h00;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule